// File: doc/BRIEF.md
# Synchronous Bus Loopback Test Slave

This block sits on the device side of a host's external memory controller. The controller is set up for synchronous, fixed-latency pseudo-static RAM accesses. It has a 32-bit data bus and a separate word-address bus. The block contains no memory array. It holds a single 32-bit test register, so the host can check the integrity of both buses through one location.

A write to word address zero loads the register with the write data. A write to any other word address loads the register with that address, zero-extended, and the write data is discarded. A read returns the register and changes nothing, so a throwaway read followed by a real read returns the same word twice. The host checks the data bus by writing random words to address zero and reading them back. It checks the address bus by writing to random non-zero addresses and reading back the captured address; shifted left by two, that value gives the host's byte address.

Each access is a single beat. The data beat arrives a fixed number of bus clocks after the address edge. A ready line is low while an access is in progress, and the host polls it after every access.

Top module: `psram_probe_slave`

## Requirements
- R1: After reset the test register reads as zero, `bus_ready` is high and `bus_data_oe` is low.
- R2: An access starts on a rising edge where `bus_cs_n` and `bus_adv_n` are both low and `bus_ready` is high. `bus_addr` and the direction are captured at that edge; `bus_we_n` low means write. `bus_ready` is low from the following cycle onward.
- R3: `bus_ready` stays low for exactly LATENCY cycles (default 3) per access, then returns high. The last of those cycles is the data beat, and the host samples read data, or the slave samples write data, at the edge that ends it.
- R4: `bus_data_oe` is high only during the data beat of a read, and only while `bus_oe_n` is low. It is low in every other cycle, including write beats.
- R5: A write to word address 0 stores the `bus_data_in` value sampled at the end of the data beat.
- R6: A write to a non-zero word address stores that address in bits [21:0] with bits [31:22] zero, and ignores `bus_data_in`.
- R7: Reads do not change the register. Back-to-back reads return the same value on `bus_data_out` during the read beat.
- R8: Start conditions seen while an access is in progress are ignored, and `bus_adv_n` low with `bus_cs_n` high starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_adv_n | input | 1 | Address valid, active low |
| bus_we_n | input | 1 | Write enable, active low (low = write) |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_addr | input | 22 | Word address |
| bus_data_in | input | 32 | Write data from the host |
| bus_data_out | output | 32 | Read data (zero when not driving) |
| bus_data_oe | output | 1 | Tri-state enable for the data pads |
| bus_ready | output | 1 | High when idle, low while an access is in progress |

## Verification
The bench looks for the address-versus-data decision at its edges. It writes to address 1 and to the all-ones address, and writes to address zero with all-zero and all-one data. A design that tested only part of the address, or sign-extended it, would read back a wrong word. It counts the busy cycles of every access: a latency counter that is off by one shows up as a short or long ready pulse, and as read data arriving in the wrong cycle. It also injects a second start in the middle of an access and a start with chip select high, reads with output-enable held high, and issues paired reads. A slave that re-latched, drove the bus without permission, or read destructively would have its register overwritten, drive unexpected data, or return different words on the paired reads.

// File: rtl/psram_probe_pkg.sv
package psram_probe_pkg;

    // Access sequencing phases
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_LATENCY = 2'd1,
        PH_BEAT    = 2'd2
    } probe_phase_e;

    // Control captured at the start of an access
    typedef struct packed {
        logic is_write;
    } probe_ctl_t;

    // Counter width that can hold the value n
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/probe_seq.sv
module probe_seq
    import psram_probe_pkg::*;
#(
    parameter int LATENCY = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cs_n,
    input  logic         adv_n,
    input  logic         we_n,
    output logic         start,
    output probe_phase_e phase,
    output probe_ctl_t   ctl
);
    localparam int CNT_W = cnt_width(LATENCY);
    localparam logic [CNT_W-1:0] LAST_WAIT = CNT_W'(LATENCY - 1);

    logic [CNT_W-1:0] cnt_q;

    assign start = (phase == PH_IDLE) && !cs_n && !adv_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase        <= PH_IDLE;
            cnt_q        <= '0;
            ctl.is_write <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        ctl.is_write <= !we_n;
                        cnt_q        <= CNT_W'(1);
                        phase        <= (LATENCY <= 1) ? PH_BEAT : PH_LATENCY;
                    end
                end
                PH_LATENCY: begin
                    if (cnt_q == LAST_WAIT) begin
                        phase <= PH_BEAT;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                PH_BEAT: phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/probe_reg.sv
module probe_reg #(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic              commit,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] value
);
    logic [ADDR_W-1:0] addr_q;
    logic              addr_zero_q;
    logic [DATA_W-1:0] addr_ext;

    // Zero-extend the latched word address to the register width
    generate
        if (DATA_W > ADDR_W) begin : g_ext
            assign addr_ext = {{(DATA_W-ADDR_W){1'b0}}, addr_q};
        end else begin : g_trunc
            assign addr_ext = addr_q[DATA_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q      <= '0;
            addr_zero_q <= 1'b0;
        end else if (start) begin
            addr_q      <= addr;
            addr_zero_q <= (addr == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (commit) begin
            value <= addr_zero_q ? data_in : addr_ext;
        end
    end
endmodule

// File: rtl/probe_drv.sv
module probe_drv
    import psram_probe_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  probe_phase_e      phase,
    input  probe_ctl_t        ctl,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] value,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              ready
);
    always_comb begin
        data_oe  = (phase == PH_BEAT) && !ctl.is_write && !oe_n;
        data_out = data_oe ? value : '0;
        ready    = (phase == PH_IDLE);
    end
endmodule

// File: rtl/psram_probe_slave.sv
module psram_probe_slave
    import psram_probe_pkg::*;
#(
    parameter int ADDR_W  = 22,
    parameter int DATA_W  = 32,
    parameter int LATENCY = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_cs_n,
    input  logic              bus_adv_n,
    input  logic              bus_we_n,
    input  logic              bus_oe_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data_in,
    output logic [DATA_W-1:0] bus_data_out,
    output logic              bus_data_oe,
    output logic              bus_ready
);
    logic              start;
    probe_phase_e      phase;
    probe_ctl_t        ctl;
    logic              commit;
    logic [DATA_W-1:0] value;

    probe_seq #(.LATENCY(LATENCY)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .cs_n  (bus_cs_n),
        .adv_n (bus_adv_n),
        .we_n  (bus_we_n),
        .start (start),
        .phase (phase),
        .ctl   (ctl)
    );

    assign commit = (phase == PH_BEAT) && ctl.is_write;

    probe_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .addr    (bus_addr),
        .commit  (commit),
        .data_in (bus_data_in),
        .value   (value)
    );

    probe_drv #(.DATA_W(DATA_W)) u_drv (
        .phase    (phase),
        .ctl      (ctl),
        .oe_n     (bus_oe_n),
        .value    (value),
        .data_out (bus_data_out),
        .data_oe  (bus_data_oe),
        .ready    (bus_ready)
    );
endmodule

// File: rtl/psram_probe_checker.sv
module psram_probe_checker #(
    parameter int ADDR_W  = 22,
    parameter int DATA_W  = 32,
    parameter int LATENCY = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_cs_n,
    input logic              bus_adv_n,
    input logic              bus_we_n,
    input logic              bus_oe_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_data_in,
    input logic [DATA_W-1:0] bus_data_out,
    input logic              bus_data_oe,
    input logic              bus_ready
);
    localparam int BW = (LATENCY < 2) ? 2 : $clog2(LATENCY + 2);

    logic [BW-1:0]     busy_len;
    logic              pend_wr;
    logic              pend_zero;
    logic [ADDR_W-1:0] pend_addr;
    logic [DATA_W-1:0] shadow;
    logic              seen_start;
    logic              beat_edge;

    assign seen_start = bus_ready && !bus_cs_n && !bus_adv_n;
    assign beat_edge  = !bus_ready && (busy_len == BW'(LATENCY - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_len  <= '0;
            pend_wr   <= 1'b0;
            pend_zero <= 1'b0;
            pend_addr <= '0;
            shadow    <= '0;
        end else begin
            busy_len <= bus_ready ? '0 : busy_len + BW'(1);
            if (seen_start) begin
                pend_wr   <= !bus_we_n;
                pend_zero <= (bus_addr == '0);
                pend_addr <= bus_addr;
            end
            if (beat_edge && pend_wr) begin
                shadow <= pend_zero ? bus_data_in : DATA_W'(pend_addr);
            end
        end
    end

    // R1: reset leaves the slave idle and off the bus
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (bus_ready && !bus_data_oe));

    // R2: a start seen while idle makes the slave busy next cycle
    p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
        seen_start |=> !bus_ready);

    // R3: busy never lasts longer than LATENCY cycles
    p_busy_bound_r3: assert property (@(posedge clk) disable iff (rst)
        !bus_ready |-> (busy_len < BW'(LATENCY)));

    // R3: ready returns right after the data beat
    p_ready_returns_r3: assert property (@(posedge clk) disable iff (rst)
        beat_edge |=> bus_ready);

    // R4: pads driven only in a permitted read beat, and never when idle
    p_drive_window_r4: assert property (@(posedge clk) disable iff (rst)
        bus_data_oe |-> (!bus_oe_n && !bus_ready && !pend_wr && beat_edge));

    // R4: a drive window lasts one cycle
    p_drive_single_r4: assert property (@(posedge clk) disable iff (rst)
        bus_data_oe |=> !bus_data_oe);

    // R5, R6, R7: read data matches the port-level shadow register
    p_read_matches_r5: assert property (@(posedge clk) disable iff (rst)
        bus_data_oe |-> (bus_data_out == shadow));
endmodule

bind psram_probe_slave psram_probe_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LATENCY(LATENCY)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_cs_n     (bus_cs_n),
    .bus_adv_n    (bus_adv_n),
    .bus_we_n     (bus_we_n),
    .bus_oe_n     (bus_oe_n),
    .bus_addr     (bus_addr),
    .bus_data_in  (bus_data_in),
    .bus_data_out (bus_data_out),
    .bus_data_oe  (bus_data_oe),
    .bus_ready    (bus_ready)
);

// File: tb/tb_psram_probe_slave.sv
module tb_psram_probe_slave;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_cs_n = 1'b1;
    logic        bus_adv_n = 1'b1;
    logic        bus_we_n = 1'b1;
    logic        bus_oe_n = 1'b1;
    logic [21:0] bus_addr = '0;
    logic [31:0] bus_data_in = '0;
    logic [31:0] bus_data_out;
    logic        bus_data_oe;
    logic        bus_ready;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] model = '0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          done = 1'b0;

    always #4 clk = ~clk;

    psram_probe_slave dut (
        .clk(clk), .rst(rst),
        .bus_cs_n(bus_cs_n), .bus_adv_n(bus_adv_n),
        .bus_we_n(bus_we_n), .bus_oe_n(bus_oe_n),
        .bus_addr(bus_addr), .bus_data_in(bus_data_in),
        .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe),
        .bus_ready(bus_ready)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops an expected read word whenever the slave drives the pads
    always @(negedge clk) begin
        if (!rst && bus_data_oe) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected drive", bus_data_out, 32'h0);
            end else begin
                logic [31:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(bus_data_out == e, t, bus_data_out, e);
            end
        end
    end

    // Driver: one access; glitch issues a second start while busy
    task automatic access(input bit wr, input logic [21:0] a,
                          input logic [31:0] d, input bit oe,
                          input bit glitch, input string tag);
        int lows;
        if (!wr && oe) begin
            exp_q.push_back(model);
            tag_q.push_back(tag);
        end
        if (wr) model = (a == 22'd0) ? d : {10'd0, a};
        @(negedge clk);
        bus_cs_n = 1'b0; bus_adv_n = 1'b0; bus_we_n = !wr;
        bus_addr = a; bus_data_in = d; bus_oe_n = 1'b1;
        @(negedge clk);
        check(bus_ready == 1'b0, "R2 busy after start", {31'd0, bus_ready}, 32'd0);
        lows = 1;
        bus_oe_n = (wr || !oe);
        if (glitch) begin
            bus_adv_n = 1'b0; bus_addr = 22'h15; bus_we_n = 1'b0;
            @(negedge clk);
            if (!bus_ready) lows++;
            bus_adv_n = 1'b1; bus_addr = a; bus_we_n = !wr;
        end else begin
            bus_adv_n = 1'b1;
        end
        for (int p = 0; p < 10 && !bus_ready; p++) begin
            @(negedge clk);
            if (!bus_ready) lows++;
        end
        check(lows == LAT, "R3 busy length", lows, LAT);
        bus_cs_n = 1'b1; bus_oe_n = 1'b1; bus_we_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle after reset, register reads zero
        check(bus_ready == 1'b1, "R1 ready after reset", {31'd0, bus_ready}, 32'd1);
        check(bus_data_oe == 1'b0, "R1 pads released", {31'd0, bus_data_oe}, 32'd0);
        access(1'b0, 22'd0, 32'd0, 1'b1, 1'b0, "R1 reset value");

        // R5 data path, R7 paired reads
        access(1'b1, 22'd0, 32'hA5A5_1234, 1'b1, 1'b0, "R5");
        access(1'b0, 22'd0, 32'd0, 1'b1, 1'b0, "R7 dummy read");
        access(1'b0, 22'd0, 32'd0, 1'b1, 1'b0, "R7 real read");
        access(1'b1, 22'd0, 32'hFFFF_FFFF, 1'b1, 1'b0, "R5");
        access(1'b0, 22'd0, 32'd0, 1'b1, 1'b0, "R5 all ones");
        access(1'b1, 22'd0, 32'h0000_0000, 1'b1, 1'b0, "R5");
        access(1'b0, 22'd0, 32'd0, 1'b1, 1'b0, "R5 all zeros");

        // R6 address capture, data ignored
        access(1'b1, 22'h2AB, 32'hDEAD_BEEF, 1'b1, 1'b0, "R6");
        access(1'b0, 22'd0, 32'd0, 1'b1, 1'b0, "R6 mid address");
        access(1'b1, 22'h3F_FFFF, 32'h1234_5678, 1'b1, 1'b0, "R6");
        access(1'b0, 22'd0, 32'd0, 1'b1, 1'b0, "R6 max address zero-extended");
        access(1'b1, 22'd1, 32'hFFFF_FFFF, 1'b1, 1'b0, "R6");
        access(1'b0, 22'd0, 32'd0, 1'b1, 1'b0, "R6 address one");

        // R4: read with output enable held high must not drive
        access(1'b0, 22'd0, 32'd0, 1'b0, 1'b0, "R4 no drive");
        check(bus_data_oe == 1'b0, "R4 released after read", {31'd0, bus_data_oe}, 32'd0);
        access(1'b0, 22'd0, 32'd0, 1'b1, 1'b0, "R4 value kept");

        // R8: start with chip select high is ignored
        @(negedge clk);
        bus_cs_n = 1'b1; bus_adv_n = 1'b0; bus_we_n = 1'b0; bus_addr = 22'h77;
        @(negedge clk);
        check(bus_ready == 1'b1, "R8 no start without select", {31'd0, bus_ready}, 32'd1);
        bus_adv_n = 1'b1; bus_we_n = 1'b1;
        access(1'b0, 22'd0, 32'd0, 1'b1, 1'b0, "R8 register unchanged");

        // R8: second start during a busy write is ignored
        access(1'b1, 22'd0, 32'hCAFE_F00D, 1'b1, 1'b1, "R8");
        access(1'b0, 22'd0, 32'd0, 1'b1, 1'b0, "R8 mid-access start ignored");

        // Mixed patterns, alternating data and address tests
        lfsr = 32'h1ACE_B00C;
        for (int i = 0; i < 24; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (i % 2 == 0) begin
                access(1'b1, 22'd0, lfsr, 1'b1, 1'b0, "R5");
                access(1'b0, 22'd0, 32'd0, 1'b1, 1'b0, "R5 pattern");
            end else begin
                access(1'b1, (lfsr[21:0] == 22'd0) ? 22'd4 : lfsr[21:0],
                       ~lfsr, 1'b1, 1'b0, "R6");
                access(1'b0, 22'd0, 32'd0, 1'b1, 1'b0, "R6 pattern");
            end
        end

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R4 all reads driven", exp_q.size(), 32'd0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule